// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block holds the interrupt flag and interrupt enable pair of a versatile-interface-adapter style peripheral. Three event sources each have a one-bit flag: a shift-register event, a second timer and a first timer. The sources sit outside the block and reach it only as per-source set and clear strobes. A byte-wide register port lets software read both registers, clear flags by writing a mask and change enables through a set/clear write. The block drives one registered interrupt request line.

The register port decodes a four-bit register index from address bits 12 down to 9, which gives sixteen byte registers. Index 13 is the flag register and index 14 is the enable register. All other indices belong to neighbouring logic: this block ignores writes to them and reads them as zero. A flag read returns a summary bit in bit 7 that is set whenever any flag is also enabled. Only the shift and first-timer sources can raise the request line. The second-timer flag is visible in the summary bit but never reaches the line.

Top module: `via_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, all flags and enables are zero and `irq` is low. A flag read returns 0x00 and an enable read returns 0x80.
- R2: A set strobe raises its flag in the next cycle. Strobe index 0 (shift) maps to flag bit 2 (0x04), index 1 (second timer) to bit 5 (0x20) and index 2 (first timer) to bit 6 (0x40).
- R3: A clear strobe on its own lowers its flag in the next cycle.
- R4: A write to index 13 clears every flag whose bit is 1 in the written byte and leaves all other flags unchanged.
- R5: A write to index 14 with bit 7 set ORs bits 6..0 of the byte into the enable register.
- R6: A write to index 14 with bit 7 clear clears every enable bit that is 1 in bits 6..0 of the byte.
- R7: A read of index 13 returns the flags in bits 6..0. Bit 7 is 1 exactly when some flag bit and the same enable bit are both 1.
- R8: A read of index 14 returns the enables in bits 6..0, and bit 7 is always 1.
- R9: `irq` is registered. It is high one cycle after the shift flag (bit 2) or the first-timer flag (bit 6) is both set and enabled, and low otherwise.
- R10: The second-timer flag (bit 5) never raises `irq`, even when it is enabled.
- R11: When a set strobe meets a clear strobe or a clearing flag write on the same flag in one cycle, the flag ends up set.
- R12: Only address bits 12..9 select the register. Writes to indices other than 13 and 14 change nothing, and reads of those indices return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 13 | Byte address; bits 12..9 select the register |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| src_set | input | 3 | Per-source flag set strobes (0 shift, 1 timer 2, 2 timer 1) |
| src_clr | input | 3 | Per-source flag clear strobes, same order |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that every input is at a known value at each clock edge, and that a strobe held high across several edges simply acts again on each edge. The bench changes inputs only on falling edges, so each pair of strobes and each write lands in exactly one cycle. The random phase favours indices 13 and 14 but also uses the other indices. It fills address bits 8..0 with noise and often drives set and clear strobes together, so the collision and decode rules are exercised inside those assumptions.

// File: rtl/via_irq_pkg.sv
// Package for the interrupt flag/enable unit: bus geometry, register
// indices and the mapping from source number to flag bit.
package via_irq_pkg;
    localparam int ADDR_W   = 13;
    localparam int SEL_LSB  = 9;
    localparam int SEL_W    = 4;
    localparam int DATA_W   = 8;
    localparam int BITS_W   = DATA_W - 1;
    localparam int NUM_SRC  = 3;
    localparam int FLAG_IDX = 13;
    localparam int EN_IDX   = 14;

    // Flags that may drive the request line: shift (bit 2) and timer 1 (bit 6).
    localparam logic [BITS_W-1:0] IRQ_MASK = 7'h44;

    // Flag bit position of each source.
    function automatic int src_pos(input int idx);
        case (idx)
            0:       return 2;
            1:       return 5;
            default: return 6;
        endcase
    endfunction
endpackage

// File: rtl/via_flag_reg.sv
// Flag register. One bit per position. A set request takes priority over
// both a clear strobe and a clearing register write in the same cycle.
// Assumes set_vec and clr_vec are already mapped to bit positions.
module via_flag_reg #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_clr,
    input  logic [WIDTH-1:0] wr_mask,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] flags
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic drop;
        assign drop = clr_vec[b] | (wr_clr & wr_mask[b]);
        // Per-bit flag update, set beating any clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          flags[b] <= 1'b0;
            else if (set_vec[b]) flags[b] <= 1'b1;
            else if (drop)       flags[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/via_enable_reg.sv
// Enable register. The top bit of a write chooses between ORing the low
// bits in and clearing the low bits that are 1.
module via_enable_reg #(
    parameter int DATA_W = 8,
    localparam int BITS_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [BITS_W-1:0] en
);
    // Set/clear update of the enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en <= '0;
        else if (wr) begin
            if (wdata[DATA_W-1]) en <= en | wdata[BITS_W-1:0];
            else                 en <= en & ~wdata[BITS_W-1:0];
        end
    end
endmodule

// File: rtl/via_irq_gen.sv
// Request generation. It forms the combinational summary of all enabled
// flags and registers the request from the subset in MASK.
module via_irq_gen #(
    parameter int WIDTH = 7,
    parameter logic [WIDTH-1:0] MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] flags,
    input  logic [WIDTH-1:0] en,
    output logic             summary,
    output logic             irq
);
    logic [WIDTH-1:0] live;
    assign live    = flags & en;
    assign summary = |live;

    // One-cycle registered request from maskable sources.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(live & MASK);
    end
endmodule

// File: rtl/via_irq_unit.sv
// Top of the interrupt flag/enable unit. It decodes the register index from
// the address, maps the source strobes to flag bits and muxes read data.
// Assumes a single-cycle write strobe and that reads have no side effects.
module via_irq_unit
    import via_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] src_set,
    input  logic [NUM_SRC-1:0] src_clr,
    output logic              irq
);
    logic [SEL_W-1:0]  sel;
    logic [BITS_W-1:0] set_vec, clr_vec;
    logic [BITS_W-1:0] flag_q, en_q;
    logic              summary;
    logic              wr_flag, wr_en;

    assign sel     = bus_addr[SEL_LSB +: SEL_W];
    assign wr_flag = bus_wr && (sel == SEL_W'(FLAG_IDX));
    assign wr_en   = bus_wr && (sel == SEL_W'(EN_IDX));

    // Map each source strobe onto its flag bit position.
    for (genvar b = 0; b < BITS_W; b++) begin : g_map
        logic s_any, c_any;
        always_comb begin
            s_any = 1'b0;
            c_any = 1'b0;
            for (int i = 0; i < NUM_SRC; i++) begin
                if (src_pos(i) == b) begin
                    s_any = s_any | src_set[i];
                    c_any = c_any | src_clr[i];
                end
            end
        end
        assign set_vec[b] = s_any;
        assign clr_vec[b] = c_any;
    end

    via_flag_reg #(.WIDTH(BITS_W)) u_flag (
        .clk(clk), .rst_n(rst_n), .wr_clr(wr_flag),
        .wr_mask(bus_wdata[BITS_W-1:0]),
        .set_vec(set_vec), .clr_vec(clr_vec), .flags(flag_q)
    );

    via_enable_reg #(.DATA_W(DATA_W)) u_en (
        .clk(clk), .rst_n(rst_n), .wr(wr_en), .wdata(bus_wdata), .en(en_q)
    );

    via_irq_gen #(.WIDTH(BITS_W), .MASK(IRQ_MASK)) u_gen (
        .clk(clk), .rst_n(rst_n), .flags(flag_q), .en(en_q),
        .summary(summary), .irq(irq)
    );

    // Read mux over the two owned indices; others read as zero.
    always_comb begin
        case (sel)
            SEL_W'(FLAG_IDX): bus_rdata = {summary, flag_q};
            SEL_W'(EN_IDX):   bus_rdata = {1'b1, en_q};
            default:          bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/via_irq_chk.sv
// Checker for via_irq_unit. It watches the ports and the flag/enable
// state and is attached to every instance through bind.
module via_irq_chk
    import via_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_SRC-1:0] src_set,
    input logic [NUM_SRC-1:0] src_clr,
    input logic              irq,
    input logic [BITS_W-1:0] flags,
    input logic [BITS_W-1:0] enables
);
    logic [SEL_W-1:0] sel;
    assign sel = bus_addr[SEL_LSB +: SEL_W];

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && enables == '0 && !irq));

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(flags & enables & IRQ_MASK)));

    // R10
    t2_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 7'h20) |=> !irq);

    // R11
    shift_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_set[0] |=> flags[2]);

    // R11
    t1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_set[2] |=> flags[6]);

    // R4
    flag_wclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_W'(FLAG_IDX) && src_set == '0)
        |=> ((flags & $past(bus_wdata[BITS_W-1:0])) == '0));

    // R8
    en_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_W'(EN_IDX)) |-> bus_rdata[DATA_W-1]);

    // R12
    other_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != SEL_W'(FLAG_IDX) && sel != SEL_W'(EN_IDX)) |-> bus_rdata == '0);
endmodule

bind via_irq_unit via_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_set(src_set),
    .src_clr(src_clr), .irq(irq), .flags(flag_q), .enables(en_q)
);

// File: tb/sim_via_irq_unit.sv
module sim_via_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [2:0]  src_set = '0, src_clr = '0;
    logic        irq;

    int total = 0, bad = 0;
    logic [6:0] fm = '0, em = '0;
    logic       im = 1'b0;
    bit         done = 0;

    always #5 clk = ~clk;

    via_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_set(src_set),
        .src_clr(src_clr), .irq(irq)
    );

    function automatic logic [6:0] to_bits(input logic [2:0] s);
        return {s[2], s[1], 2'b00, s[0], 2'b00};
    endfunction

    function automatic logic [7:0] rd_model(input int idx, input logic [6:0] f,
                                            input logic [6:0] e);
        if (idx == 13) return {|(f & e), f};
        if (idx == 14) return {1'b1, e};
        return 8'h00;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, update model, check after the rise.
    task automatic step(input int idx, input bit we, input logic [7:0] wd,
                        input logic [2:0] s, input logic [2:0] c);
        logic [6:0] sv, fn, en_n;
        @(negedge clk);
        bus_addr  = {4'(idx), 9'($urandom)};
        bus_wr    = we;
        bus_wdata = wd;
        src_set   = s;
        src_clr   = c;
        sv = to_bits(s);
        fn = fm & ~to_bits(c);
        if (we && idx == 13) fn = fn & ~wd[6:0];
        fn = fn | sv;
        en_n = em;
        if (we && idx == 14) en_n = wd[7] ? (em | wd[6:0]) : (em & ~wd[6:0]);
        @(posedge clk);
        #1;
        im = |(fm & em & 7'h44);
        fm = fn;
        em = en_n;
        check("R9 irq", {7'b0, irq}, {7'b0, im});
        check(idx == 13 ? "R7 flag read" : idx == 14 ? "R8 enable read" : "R12 other read",
              bus_rdata, rd_model(idx, fm, em));
        bus_wr = 1'b0; src_set = '0; src_clr = '0;
    endtask

    function automatic logic [7:0] peek(input int idx);
        bus_addr = {4'(idx), 9'h1a5};
        return 8'h00;
    endfunction

    task automatic look(input int idx, input string tag, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = {4'(idx), 9'h1a5};
        #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
        look(13, "R1 flag read", 8'h00);
        look(14, "R1 enable read", 8'h80);

        // R2 each source sets its bit
        step(0, 0, 0, 3'b001, 0); look(13, "R2 shift bit", 8'h04);
        step(0, 0, 0, 3'b010, 0); look(13, "R2 t2 bit", 8'h24);
        step(0, 0, 0, 3'b100, 0); look(13, "R2 t1 bit", 8'h64);
        // R10 only t2 enabled: summary yes, irq no
        step(14, 1, 8'hA0, 0, 0); look(13, "R7 summary t2", 8'hE4);
        step(0, 0, 0, 0, 0); check("R10 t2 no irq", {7'b0, irq}, 8'h00);
        // R5 enable shift -> irq two cycles later
        step(14, 1, 8'h84, 0, 0); look(14, "R5 enable or", 8'hA4);
        step(0, 0, 0, 0, 0); check("R9 shift irq", {7'b0, irq}, 8'h01);
        // R6 clear enables
        step(14, 1, 8'h24, 0, 0); look(14, "R6 enable clear", 8'h80);
        // R3 clear strobe
        step(0, 0, 0, 0, 3'b001); look(13, "R3 shift cleared", 8'h60);
        // R4 mask write clears only t1
        step(13, 1, 8'hC0, 0, 0); look(13, "R4 mask clear", 8'h20);
        // R11 set beats clear strobe and write clear
        step(13, 1, 8'h7F, 3'b100, 3'b100); look(13, "R11 set wins", 8'h40);
        // R12 writes to other indices ignored
        step(12, 1, 8'hFF, 0, 0); step(15, 1, 8'h7F, 0, 0);
        look(13, "R12 flags unchanged", 8'h40);
        look(14, "R12 enables unchanged", 8'h80);

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            int r, idx;
            r = $urandom_range(0, 9);
            idx = (r < 4) ? 13 : (r < 8) ? 14 : $urandom_range(0, 15);
            step(idx, $urandom_range(0, 1), 8'($urandom),
                 3'($urandom) & 3'($urandom), 3'($urandom) & 3'($urandom));
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule